// File: doc/BRIEF.md
# Zone Protection Rights Checker

This block settles the access rights for a translation hit on an embedded core whose TLB entries carry a zone number. A 32-bit zone protection word holds one 2-bit code per zone. The entry's zone index picks one code. That code can grant every right, deny a problem-state (user) access outright, or leave the decision to the rights stored in the TLB entry. Which of these happens also depends on the privilege state. The block returns the final read/write/execute vector and a grant bit. A grant of 0 means a protection fault.

A request is one beat on a valid/ready input. It carries the zone protection word, the zone index, the entry's stored rights, the privilege state and the access kind. The answer comes out of a single output register one cycle after the beat is accepted. The output side has its own valid/ready pair, and back-pressure works as follows:
- While a response is held and not taken, `req_ready` is low and no new request is accepted.
- The held response keeps its values unchanged.
- In the cycle the response is taken, a new request may be accepted at the same time.

Rights vectors use bit 0 for read, bit 1 for write and bit 2 for execute.

Top module: `zone_prot_checker`

## Requirements
- R1: Zone code 3 yields rights 3'b111 and a grant in both privilege states, for every access kind.
- R2: Zone code 2 yields rights 3'b111 and a grant in supervisor state (`req_user`=0). In user state (`req_user`=1) it defers to the entry rights as in R5.
- R3: Zone code 0 in user state yields rights 3'b000 and no grant, whatever the access kind and the entry rights.
- R4: Zone code 0 in supervisor state, and zone code 1 in either state, defer to the entry rights as in R5.
- R5: A deferred decision outputs the entry rights OR-ed with the execute bit (bit 2), so the result is `req_entry_perm | 3'b100`.
- R6: The grant depends on the access kind. A fetch (`req_fetch`=1) needs execute (bit 2). A store (`req_store`=1, `req_fetch`=0) needs write (bit 1). A load (both 0) needs read (bit 0). When both flags are set, `req_fetch` takes precedence.
- R7: Zone n's code sits at bits [2*(15-n)+1 : 2*(15-n)] of `req_zone_prot`, so zone 0 occupies the two most significant bits.
- R8: A request accepted at a clock edge gives `rsp_valid`=1 and its result on `rsp_perm`/`rsp_grant` after that edge.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, the response stays valid and unchanged.
- R10: During and right after reset, `rsp_valid`, `rsp_perm` and `rsp_grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_zone_prot | input | 32 | Sixteen 2-bit zone codes, zone 0 at the top |
| req_zone_idx | input | 4 | Zone number of the hit entry |
| req_entry_perm | input | 3 | Entry rights {exec, write, read} |
| req_user | input | 1 | 1 = problem (user) state, 0 = supervisor |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_store | input | 1 | Access is a data store (ignored when fetch) |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_perm | output | 3 | Final rights {exec, write, read} |
| rsp_grant | output | 1 | 1 = access allowed, 0 = protection fault |

## Verification
The bench sweeps every zone code, both privilege states, the three access kinds and all eight entry-rights patterns. In each case every other zone field holds the inverted code, so a design that reads the wrong field, or reads the fields in reversed order, returns rights for the wrong code. Several cases would expose specific mistakes:
- A zone code 2 that is not split by privilege gives a user store full rights.
- A zone code 0 that does not fault in user state lets a user fetch through.
- A deferral that drops the forced execute bit faults a fetch from an entry with no execute right.
- A decoder that checks the store flag before the fetch flag grades a fetch against write.

A stalled response is checked for holding its values and for blocking the next request until the consumer takes it.

// File: rtl/zpc_pkg.sv
package zpc_pkg;

  // Bit positions inside a rights vector
  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;
  localparam logic [PERM_W-1:0] PERM_ALL  = 3'b111;
  localparam logic [PERM_W-1:0] PERM_NONE = 3'b000;
  localparam logic [PERM_W-1:0] PERM_EXEC = 3'b100;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    ZC_USER_DENY = 2'd0,
    ZC_DEFER     = 2'd1,
    ZC_SUP_FULL  = 2'd2,
    ZC_FULL      = 2'd3
  } zone_code_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic [PERM_W-1:0] perm;
    logic              grant;
  } zpc_result_t;

endpackage

// File: rtl/zpc_zone_sel.sv
module zpc_zone_sel
  import zpc_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  localparam int IDX_W = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
  localparam int ZPR_W = CODE_W * NUM_ZONES
) (
  input  logic [ZPR_W-1:0] zone_prot,
  input  logic [IDX_W-1:0] zone_idx,
  output zone_code_e       code
);

  logic [CODE_W-1:0] fields [NUM_ZONES];

  // Zone 0 lives in the most significant field
  for (genvar n = 0; n < NUM_ZONES; n++) begin : g_field
    assign fields[n] = zone_prot[CODE_W*(NUM_ZONES-1-n) +: CODE_W];
  end

  always_comb begin
    if (int'(zone_idx) < NUM_ZONES) code = zone_code_e'(fields[zone_idx]);
    else                            code = ZC_USER_DENY;
  end

endmodule

// File: rtl/zpc_rights.sv
module zpc_rights
  import zpc_pkg::*;
(
  input  zone_code_e        code,
  input  logic              user,
  input  acc_kind_e         kind,
  input  logic [PERM_W-1:0] entry_perm,
  output zpc_result_t       result
);

  logic              defer;
  logic [PERM_W-1:0] perm;
  logic              grant;

  always_comb begin
    defer = 1'b0;
    perm  = PERM_NONE;
    unique case (code)
      ZC_FULL:      perm = PERM_ALL;
      ZC_SUP_FULL:  if (user) defer = 1'b1; else perm = PERM_ALL;
      ZC_USER_DENY: if (user) perm = PERM_NONE; else defer = 1'b1;
      default:      defer = 1'b1;
    endcase
    if (defer) perm = entry_perm | PERM_EXEC;
  end

  always_comb begin
    unique case (kind)
      ACC_FETCH: grant = perm[PERM_EX];
      ACC_STORE: grant = perm[PERM_WR];
      default:   grant = perm[PERM_RD];
    endcase
  end

  assign result = '{perm: perm, grant: grant};

endmodule

// File: rtl/zpc_out_reg.sv
module zpc_out_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/zone_prot_checker.sv
module zone_prot_checker
  import zpc_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  localparam int IDX_W = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
  localparam int ZPR_W = CODE_W * NUM_ZONES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ZPR_W-1:0]  req_zone_prot,
  input  logic [IDX_W-1:0]  req_zone_idx,
  input  logic [PERM_W-1:0] req_entry_perm,
  input  logic              req_user,
  input  logic              req_fetch,
  input  logic              req_store,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              rsp_grant
);

  localparam int RES_W = $bits(zpc_result_t);

  zone_code_e  code;
  acc_kind_e   kind;
  zpc_result_t comb_res;
  zpc_result_t held_res;

  // Fetch wins over store
  assign kind = req_fetch ? ACC_FETCH : (req_store ? ACC_STORE : ACC_LOAD);

  zpc_zone_sel #(.NUM_ZONES(NUM_ZONES)) u_sel (
    .zone_prot (req_zone_prot),
    .zone_idx  (req_zone_idx),
    .code      (code)
  );

  zpc_rights u_rights (
    .code       (code),
    .user       (req_user),
    .kind       (kind),
    .entry_perm (req_entry_perm),
    .result     (comb_res)
  );

  zpc_out_reg #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (comb_res),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (held_res)
  );

  assign rsp_perm  = held_res.perm;
  assign rsp_grant = held_res.grant;

endmodule

// File: rtl/zpc_checker.sv
module zpc_checker #(
  parameter int NUM_ZONES = 16,
  localparam int IDX_W = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
  localparam int ZPR_W = 2 * NUM_ZONES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ZPR_W-1:0] req_zone_prot,
  input logic [IDX_W-1:0] req_zone_idx,
  input logic             req_user,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [2:0]       rsp_perm,
  input logic             rsp_grant
);

  logic       accept;
  logic [1:0] picked;

  assign accept = req_valid && req_ready;
  assign picked = req_zone_prot[2*(NUM_ZONES-1-int'(req_zone_idx)) +: 2];

  AST_FULL_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && picked == 2'd3 |=> rsp_perm == 3'b111 && rsp_grant); // R1
  AST_USER_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && picked == 2'd0 && req_user |=> rsp_perm == 3'b000 && !rsp_grant); // R3
  AST_EXEC_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_perm[2] |-> rsp_perm == 3'b000); // R5
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_perm) && $stable(rsp_grant)); // R9

endmodule

bind zone_prot_checker zpc_checker #(.NUM_ZONES(NUM_ZONES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_zone_prot (req_zone_prot),
  .req_zone_idx  (req_zone_idx),
  .req_user      (req_user),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_perm      (rsp_perm),
  .rsp_grant     (rsp_grant)
);

// File: tb/zone_prot_checker_tb_top.sv
`timescale 1ns/1ps
module zone_prot_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_zone_prot = '0;
  logic [3:0]  req_zone_idx = '0;
  logic [2:0]  req_entry_perm = '0;
  logic        req_user = 1'b0;
  logic        req_fetch = 1'b0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_perm;
  logic        rsp_grant;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zone_prot_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_zone_prot(req_zone_prot), .req_zone_idx(req_zone_idx),
    .req_entry_perm(req_entry_perm), .req_user(req_user),
    .req_fetch(req_fetch), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_perm(rsp_perm), .rsp_grant(rsp_grant)
  );

  typedef struct packed {
    logic [1:0] code;
    logic       user;
    logic       fetch;
    logic       store;
    logic [2:0] eperm;
    logic [2:0] xperm;
    logic       xgrant;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{2'd3, 1'b1, 1'b0, 1'b1, 3'b000, 3'b111, 1'b1}, // R1
    '{2'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b111, 1'b1}, // R1
    '{2'd2, 1'b0, 1'b0, 1'b1, 3'b000, 3'b111, 1'b1}, // R2
    '{2'd2, 1'b1, 1'b0, 1'b1, 3'b001, 3'b101, 1'b0}, // R2
    '{2'd2, 1'b1, 1'b0, 1'b0, 3'b001, 3'b101, 1'b1}, // R2
    '{2'd0, 1'b1, 1'b1, 1'b0, 3'b111, 3'b000, 1'b0}, // R3
    '{2'd0, 1'b1, 1'b0, 1'b0, 3'b111, 3'b000, 1'b0}, // R3
    '{2'd0, 1'b0, 1'b0, 1'b1, 3'b010, 3'b110, 1'b1}, // R4
    '{2'd1, 1'b0, 1'b0, 1'b0, 3'b010, 3'b110, 1'b0}, // R4
    '{2'd1, 1'b1, 1'b1, 1'b0, 3'b000, 3'b100, 1'b1}, // R5
    '{2'd1, 1'b1, 1'b1, 1'b1, 3'b000, 3'b100, 1'b1}, // R6
    '{2'd1, 1'b0, 1'b0, 1'b1, 3'b011, 3'b111, 1'b1}  // R6
  };

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Zone idx holds code, all others hold the inverted code (zone 0 at MSBs)
  function automatic logic [31:0] make_zpr(input int idx, input logic [1:0] code);
    logic [31:0] z;
    for (int n = 0; n < 16; n++) z[2*(15-n) +: 2] = (n == idx) ? code : ~code;
    return z;
  endfunction

  // Expected {perm, grant} from the requirements
  function automatic logic [3:0] model(input logic [1:0] code, input logic user,
                                       input logic fetch, input logic store, input logic [2:0] ep);
    logic [2:0] p;
    logic g;
    if (code == 2'd3 || (code == 2'd2 && !user)) p = 3'b111;
    else if (code == 2'd0 && user)               p = 3'b000;
    else                                         p = ep | 3'b100;
    if (fetch)      g = p[2];
    else if (store) g = p[1];
    else            g = p[0];
    return {p, g};
  endfunction

  task automatic send(input logic [31:0] zpr, input int idx, input logic user,
                      input logic fetch, input logic store, input logic [2:0] ep);
    @(negedge clk);
    req_zone_prot  = zpr;
    req_zone_idx   = idx[3:0];
    req_user       = user;
    req_fetch      = fetch;
    req_store      = store;
    req_entry_perm = ep;
    req_valid      = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_one(input logic [31:0] zpr, input int idx, input logic [1:0] code,
                         input logic user, input logic fetch, input logic store,
                         input logic [2:0] ep, input logic [3:0] exp, input string req);
    send(zpr, idx, user, fetch, store, ep);
    check(rsp_valid == 1'b1, {req, " rsp_valid (R8)"}, {3'b0, rsp_valid}, 4'h1);
    check({rsp_perm, rsp_grant} == exp, req, {rsp_perm, rsp_grant}, exp);
    if (code != model(code, user, fetch, store, ep) || 1) ; // code kept for naming only
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_perm == 3'b000 && rsp_grant == 1'b0, "R10 in reset",
          {rsp_perm, rsp_valid}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_perm == 3'b000 && rsp_grant == 1'b0, "R10 after reset",
          {rsp_perm, rsp_grant}, 4'h0);
    check(req_ready == 1'b1, "R9 ready when empty", {3'b0, req_ready}, 4'h1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      run_one(make_zpr(i % 16, VEC[i].code), i % 16, VEC[i].code, VEC[i].user,
              VEC[i].fetch, VEC[i].store, VEC[i].eperm, {VEC[i].xperm, VEC[i].xgrant},
              $sformatf("vec%0d R1/R2/R3/R4/R5/R6", i));
    end

    // Full sweep: code, privilege, kind, entry rights
    for (int c = 0; c < 4; c++)
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 3; k++)
          for (int e = 0; e < 8; e++) begin
            int idx = (c * 7 + e + k) % 16;
            logic f = (k == 2);
            logic s = (k == 1);
            run_one(make_zpr(idx, c[1:0]), idx, c[1:0], u[0], f, s, e[2:0],
                    model(c[1:0], u[0], f, s, e[2:0]),
                    $sformatf("sweep c%0d u%0d k%0d e%0d R6 R7", c, u, k, e));
          end

    // R7: zone 0 is the top field
    run_one(32'hC000_0000, 0, 2'd3, 1'b1, 1'b0, 1'b1, 3'b000, 4'b1111, "R7 zone0 msb");
    run_one(32'hC000_0000, 15, 2'd0, 1'b1, 1'b0, 1'b1, 3'b111, 4'b0000, "R7 zone15 lsb");
    run_one(32'h0000_0003, 15, 2'd3, 1'b1, 1'b1, 1'b0, 3'b000, 4'b1111, "R7 zone15 full");

    // R9: back-pressure
    rsp_ready = 1'b0;
    send(make_zpr(4, 2'd3), 4, 1'b1, 1'b0, 1'b1, 3'b000);  // A -> 1111
    check(rsp_valid && {rsp_perm, rsp_grant} == 4'b1111, "R9 A held",
          {rsp_perm, rsp_grant}, 4'b1111);
    check(req_ready == 1'b0, "R9 ready low on stall", {3'b0, req_ready}, 4'h0);
    @(negedge clk);
    req_zone_prot = make_zpr(5, 2'd0);
    req_zone_idx = 4'd5;
    req_user = 1'b1;
    req_fetch = 1'b1;
    req_store = 1'b0;
    req_entry_perm = 3'b111;
    req_valid = 1'b1;                                       // B -> 0000
    @(negedge clk);
    check(rsp_valid && {rsp_perm, rsp_grant} == 4'b1111, "R9 A unchanged under stall",
          {rsp_perm, rsp_grant}, 4'b1111);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && {rsp_perm, rsp_grant} == 4'b0000, "R9 B after release",
          {rsp_perm, rsp_grant}, 4'b0000);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 drained", {3'b0, rsp_valid}, 4'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule